// File: doc/BRIEF.md
# Memory-to-Peripheral Bus Bridge with Two Width Frames

This bridge lets a processor's 32-bit memory bus reach a slower peripheral bus. The memory bus has a separate read request path and a separate write request path. The bridge merges both onto one shared peripheral bus. That bus has a 16-bit address, a 32-bit write data path, one read strobe, one write strobe and one width flag. The bridge decodes which of two address windows ("frames") a request targets and raises that frame's select. It then returns read data and a completion pulse to the requester.

The wide frame takes both 16-bit and 32-bit accesses, and a 32-bit access there uses a single bus cycle. The narrow frame only understands 16-bit accesses, so that older peripherals keep working. A 32-bit request to the narrow frame is therefore carried out as two 16-bit accesses: the low word goes to the addressed location and the high word to the next one. A request outside both windows finishes at once with an error indication and does not touch the peripheral bus.

A requester raises its request with the address, width and write data, and holds them stable until its own done pulse appears. It drops the request in the done cycle. The peripherals answer in the same cycle they are strobed.

Top module: `pbb_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, no strobe, frame select, width flag, done pulse or error is active, and read data is zero.
- R2: The wide frame covers memory word addresses 0x0800 to 0x0FFF and the narrow frame covers 0x7000 to 0x77FF. Every other address, including 0x07FF, 0x1000 and 0x7800, is outside both frames. The peripheral address is the low 16 bits of the memory address.
- R3: A 16-bit access to the wide frame uses one strobe cycle with the width flag low. Write data is driven in bits 15:0 with bits 31:16 zero, and read data comes back zero-extended. Done appears in the second cycle after the request is first sampled.
- R4: A 32-bit access to the wide frame uses one strobe cycle with the width flag high. It carries all 32 data bits, and done appears in the second cycle after the request is sampled.
- R5: A 16-bit access to the narrow frame uses one strobe cycle with the width flag low, and read data comes back zero-extended.
- R6: A 32-bit access to the narrow frame uses two strobe cycles in a row with the width flag low. The first goes to the given address and carries data bits 15:0. The second goes to that address plus one and carries data bits 31:16. Read data is assembled as {second word, first word}, and done appears only in the cycle after the second strobe.
- R7: When a read request and a write request are both pending while the bridge is idle, the write is performed first and the read follows once the write's done has been given.
- R8: An access outside both frames produces no strobe and no frame select. Done appears in the first cycle after the request is sampled, the error output is high in that same cycle, and a read returns zero.
- R9: Read data is zero in every cycle in which read done is low.
- R10: Every wide-frame access holds its frame select for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, held until rd_done |
| rd_addr | input | 32 | Read word address |
| rd_wide | input | 1 | Read is 32 bits when high, 16 bits when low |
| wr_req | input | 1 | Write request, held until wr_done |
| wr_addr | input | 32 | Write word address |
| wr_wide | input | 1 | Write is 32 bits when high, 16 bits when low |
| wr_data | input | 32 | Write data, low half used for 16-bit writes |
| rd_data | output | 32 | Read result, valid with rd_done, zero otherwise |
| rd_done | output | 1 | One-cycle read completion |
| wr_done | output | 1 | One-cycle write completion |
| acc_err | output | 1 | High with done when the address hit no frame |
| p_addr | output | 16 | Peripheral address |
| p_wdata | output | 32 | Peripheral write data |
| p_rd | output | 1 | Peripheral read strobe |
| p_wr | output | 1 | Peripheral write strobe |
| p_wide | output | 1 | Peripheral access is 32 bits |
| f1_sel | output | 1 | Wide-frame select |
| f2_sel | output | 1 | Narrow-frame select |
| f1_rdata | input | 32 | Read data returned by the wide frame |
| f2_rdata | input | 16 | Read data returned by the narrow frame |

## Verification
A sequencer stuck in or skipping its second half-word phase shows at the ports within one cycle. The narrow-frame strobe count is wrong, the second address is not the first plus one, or done arrives a cycle early or late. A wrong frame decision is visible in the same cycle the strobe starts, as the wrong select, the wrong width flag, or an error pulse instead of a strobe. A stale error or read-data register shows up at the very next done pulse, either as a spurious error or as nonzero read data from an unmapped address.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {FR_NONE, FR_WIDE, FR_NARROW} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DONE} state_e;

  // a 32-bit request to the 16-bit-only frame needs two bus beats
  function automatic logic needs_split(input frame_e fr, input logic wide);
    return (fr == FR_NARROW) && wide;
  endfunction

  // write data placed on the peripheral bus for a given beat
  function automatic logic [DATA_W-1:0] beat_wdata(input frame_e fr, input logic wide,
                                                   input logic hi_beat,
                                                   input logic [DATA_W-1:0] wd);
    if (fr == FR_WIDE && wide) return wd;
    if (hi_beat)               return {{HALF_W{1'b0}}, wd[DATA_W-1:HALF_W]};
    return {{HALF_W{1'b0}}, wd[HALF_W-1:0]};
  endfunction

  // final read value returned to the memory side
  function automatic logic [DATA_W-1:0] merge_read(input frame_e fr, input logic wide,
                                                   input logic [HALF_W-1:0] lo_word,
                                                   input logic [DATA_W-1:0] f1,
                                                   input logic [HALF_W-1:0] f2);
    case (fr)
      FR_WIDE:   return wide ? f1 : {{HALF_W{1'b0}}, f1[HALF_W-1:0]};
      FR_NARROW: return wide ? {f2, lo_word} : {{HALF_W{1'b0}}, f2};
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/pbb_arb.sv
module pbb_arb
  import pbb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_wide,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_wide,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pick_valid,
  output logic              pick_write,
  output logic [AW-1:0]     pick_addr,
  output logic              pick_wide,
  output logic [DATA_W-1:0] pick_wdata
);
  // writes win over reads on the shared bus
  always_comb begin
    pick_valid = wr_req | rd_req;
    pick_write = wr_req;
    pick_addr  = wr_req ? wr_addr : rd_addr;
    pick_wide  = wr_req ? wr_wide : rd_wide;
    pick_wdata = wr_data;
  end
endmodule

// File: rtl/pbb_decode.sv
module pbb_decode
  import pbb_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            WIN_BITS = 11,
  parameter logic [AW-1:0] F1_BASE  = 32'h0000_0800,
  parameter logic [AW-1:0] F2_BASE  = 32'h0000_7000
) (
  input  logic [AW-1:0] addr,
  output frame_e        frame
);
  localparam int TAG_LO = WIN_BITS;

  logic hit_wide, hit_narrow;
  assign hit_wide   = (addr[AW-1:TAG_LO] == F1_BASE[AW-1:TAG_LO]);
  assign hit_narrow = (addr[AW-1:TAG_LO] == F2_BASE[AW-1:TAG_LO]);

  always_comb begin
    if (hit_wide)        frame = FR_WIDE;
    else if (hit_narrow) frame = FR_NARROW;
    else                 frame = FR_NONE;
  end
endmodule

// File: rtl/pbb_seq.sv
module pbb_seq
  import pbb_pkg::*;
#(
  parameter int PAW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pick_write,
  input  logic              pick_wide,
  input  logic [PAW-1:0]    pick_addr,
  input  logic [DATA_W-1:0] pick_wdata,
  input  frame_e            pick_frame,
  input  logic [DATA_W-1:0] f1_rdata,
  input  logic [HALF_W-1:0] f2_rdata,
  output logic              idle,
  output logic              split_lo,
  output logic [PAW-1:0]    p_addr,
  output logic [DATA_W-1:0] p_wdata,
  output logic              p_rd,
  output logic              p_wr,
  output logic              p_wide,
  output logic              f1_sel,
  output logic              f2_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              wr_done,
  output logic              acc_err
);
  state_e            state_q;
  frame_e            frame_q;
  logic              is_wr_q, wide_q, phase_q, err_q;
  logic [PAW-1:0]    addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [HALF_W-1:0] lo_q;
  logic              in_acc, in_done;

  assign idle     = (state_q == ST_IDLE);
  assign in_acc   = (state_q == ST_ACC);
  assign in_done  = (state_q == ST_DONE);
  assign split_lo = in_acc && needs_split(frame_q, wide_q) && !phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= FR_NONE;
      is_wr_q <= 1'b0;
      wide_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          is_wr_q <= pick_write;
          wide_q  <= pick_wide;
          frame_q <= pick_frame;
          addr_q  <= pick_addr;
          wdata_q <= pick_wdata;
          phase_q <= 1'b0;
          if (pick_frame == FR_NONE) begin
            state_q <= ST_DONE;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else begin
            state_q <= ST_ACC;
            err_q   <= 1'b0;
          end
        end
        ST_ACC: if (split_lo) begin
          lo_q    <= f2_rdata;
          phase_q <= 1'b1;
          addr_q  <= addr_q + {{(PAW-1){1'b0}}, 1'b1};
        end else begin
          rdata_q <= merge_read(frame_q, wide_q, lo_q, f1_rdata, f2_rdata);
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign p_rd    = in_acc && !is_wr_q;
  assign p_wr    = in_acc && is_wr_q;
  assign f1_sel  = in_acc && (frame_q == FR_WIDE);
  assign f2_sel  = in_acc && (frame_q == FR_NARROW);
  assign p_wide  = f1_sel && wide_q;
  assign p_addr  = in_acc ? addr_q : '0;
  assign p_wdata = (in_acc && is_wr_q) ? beat_wdata(frame_q, wide_q, phase_q, wdata_q) : '0;
  assign rd_done = in_done && !is_wr_q;
  assign wr_done = in_done && is_wr_q;
  assign acc_err = in_done && err_q;
  assign rd_data = rd_done ? rdata_q : '0;
endmodule

// File: rtl/pbb_bridge.sv
module pbb_bridge
  import pbb_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            PAW      = 16,
  parameter int            WIN_BITS = 11,
  parameter logic [AW-1:0] F1_BASE  = 32'h0000_0800,
  parameter logic [AW-1:0] F2_BASE  = 32'h0000_7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_wide,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_wide,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic              wr_done,
  output logic              acc_err,
  output logic [PAW-1:0]    p_addr,
  output logic [DATA_W-1:0] p_wdata,
  output logic              p_rd,
  output logic              p_wr,
  output logic              p_wide,
  output logic              f1_sel,
  output logic              f2_sel,
  input  logic [DATA_W-1:0] f1_rdata,
  input  logic [HALF_W-1:0] f2_rdata
);
  logic              pick_valid, pick_write, pick_wide;
  logic [AW-1:0]     pick_addr;
  logic [DATA_W-1:0] pick_wdata;
  frame_e            pick_frame;
  logic              idle, start, split_lo;

  pbb_arb #(.AW(AW)) u_arb (
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .pick_valid(pick_valid), .pick_write(pick_write), .pick_addr(pick_addr),
    .pick_wide(pick_wide), .pick_wdata(pick_wdata)
  );

  pbb_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .F1_BASE(F1_BASE), .F2_BASE(F2_BASE)) u_dec (
    .addr(pick_addr), .frame(pick_frame)
  );

  assign start = idle && pick_valid;

  pbb_seq #(.PAW(PAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pick_write(pick_write), .pick_wide(pick_wide), .pick_addr(pick_addr[PAW-1:0]),
    .pick_wdata(pick_wdata), .pick_frame(pick_frame),
    .f1_rdata(f1_rdata), .f2_rdata(f2_rdata),
    .idle(idle), .split_lo(split_lo),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rd(p_rd), .p_wr(p_wr), .p_wide(p_wide),
    .f1_sel(f1_sel), .f2_sel(f2_sel),
    .rd_data(rd_data), .rd_done(rd_done), .wr_done(wr_done), .acc_err(acc_err)
  );
endmodule

// File: rtl/pbb_bridge_chk.sv
module pbb_bridge_chk #(
  parameter int PAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_req,
  input logic           wr_req,
  input logic           idle,
  input logic           split_lo,
  input logic [PAW-1:0] p_addr,
  input logic           p_rd,
  input logic           p_wr,
  input logic           f1_sel,
  input logic           f2_sel,
  input logic           rd_done,
  input logic [31:0]    rd_data,
  input logic           acc_err
);
  // R7
  wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_req && rd_req) |=> (!p_rd && !rd_done));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && rd_done) |-> (rd_data == 32'h0));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(!p_rd && !p_wr && !f1_sel && !f2_sel));

  // R6
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    split_lo |=> (f2_sel && (p_addr == $past(p_addr) + {{(PAW-1){1'b0}}, 1'b1})));

  // R10
  f1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f1_sel |=> !f1_sel);
endmodule

bind pbb_bridge pbb_bridge_chk #(.PAW(PAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .idle(idle),
  .split_lo(split_lo), .p_addr(p_addr), .p_rd(p_rd), .p_wr(p_wr),
  .f1_sel(f1_sel), .f2_sel(f2_sel), .rd_done(rd_done), .rd_data(rd_data),
  .acc_err(acc_err)
);

// File: tb/pbb_bridge_bench.sv
module pbb_bridge_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0, rd_wide = 1'b0, wr_req = 1'b0, wr_wide = 1'b0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic [31:0] rd_data, p_wdata, f1_rdata;
  logic        rd_done, wr_done, acc_err, p_rd, p_wr, p_wide, f1_sel, f2_sel;
  logic [15:0] p_addr, f2_rdata;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  pbb_bridge u_pbb_bridge (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .rd_data(rd_data), .rd_done(rd_done), .wr_done(wr_done), .acc_err(acc_err),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rd(p_rd), .p_wr(p_wr), .p_wide(p_wide),
    .f1_sel(f1_sel), .f2_sel(f2_sel), .f1_rdata(f1_rdata), .f2_rdata(f2_rdata)
  );

  // peripheral models: each word holds a fixed pattern of its address
  function automatic logic [15:0] w1(input logic [15:0] a); return a ^ 16'hA5C3; endfunction
  function automatic logic [15:0] w2(input logic [15:0] a); return a ^ 16'h3C5A; endfunction
  assign f1_rdata = f1_sel ? {p_wide ? w1(p_addr + 16'd1) : 16'h0, w1(p_addr)} : 32'h0;
  assign f2_rdata = f2_sel ? w2(p_addr) : 16'h0;

  // expected frame from the address map in R2: 0 none, 1 wide, 2 narrow
  function automatic int frame_of(input logic [31:0] a);
    if (a >= 32'h0800 && a <= 32'h0FFF) return 1;
    if (a >= 32'h7000 && a <= 32'h77FF) return 2;
    return 0;
  endfunction

  function automatic string tag_of(input int fr, input logic wide);
    if (fr == 0) return "R8";
    if (fr == 1) return wide ? "R4" : "R3";
    return wide ? "R6" : "R5";
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // beat log filled while an access runs
  logic [15:0] b_addr [4];
  logic [31:0] b_wdata [4];
  logic        b_wide [4];
  logic        b_f1 [4];
  logic        b_f2 [4];
  int          n_beats, n_cyc;
  logic        got_err;
  logic [31:0] got_rd;

  task automatic watch_beat;
    if (p_rd || p_wr) begin
      if (n_beats < 4) begin
        b_addr[n_beats]  = p_addr;
        b_wdata[n_beats] = p_wdata;
        b_wide[n_beats]  = p_wide;
        b_f1[n_beats]    = f1_sel;
        b_f2[n_beats]    = f2_sel;
      end
      n_beats++;
    end
  endtask

  task automatic run_access(input logic wr, input logic wide, input logic [31:0] addr,
                            input logic [31:0] wd);
    @(negedge clk);
    if (wr) begin wr_req = 1'b1; wr_addr = addr; wr_wide = wide; wr_data = wd; end
    else    begin rd_req = 1'b1; rd_addr = addr; rd_wide = wide; end
    n_beats = 0; n_cyc = 0; got_err = 1'b0; got_rd = '0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      n_cyc++;
      watch_beat();
      if (rd_done || wr_done) begin
        got_err = acc_err;
        got_rd  = rd_data;
        break;
      end
    end
    wr_req = 1'b0; rd_req = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [31:0] addr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h0000_0812, 32'h0},
    '{1'b0, 1'b1, 32'h0000_0FFE, 32'h0},
    '{1'b1, 1'b0, 32'h0000_0800, 32'hDEAD_BEEF},
    '{1'b1, 1'b1, 32'h0000_0A40, 32'h1234_5678},
    '{1'b0, 1'b0, 32'h0000_7004, 32'h0},
    '{1'b0, 1'b1, 32'h0000_77FE, 32'h0},
    '{1'b1, 1'b1, 32'h0000_7100, 32'hCAFE_F00D},
    '{1'b1, 1'b0, 32'h0000_77FF, 32'h0000_9A9A},
    '{1'b0, 1'b0, 32'h0000_1000, 32'h0},
    '{1'b1, 1'b1, 32'h0000_07FF, 32'h5555_AAAA},
    '{1'b0, 1'b1, 32'h0000_7800, 32'h0}
  };

  initial begin
    #(PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!(p_rd || p_wr || f1_sel || f2_sel || p_wide), "R1", "strobes in reset",
        {27'h0, p_rd, p_wr, f1_sel, f2_sel, p_wide}, 32'h0);
    chk(!(rd_done || wr_done || acc_err) && rd_data == 0, "R1", "done/err in reset",
        {29'h0, rd_done, wr_done, acc_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(p_rd || p_wr || rd_done || wr_done || acc_err), "R1", "idle after reset",
        {27'h0, p_rd, p_wr, rd_done, wr_done, acc_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t  v = VEC[i];
      int    fr = frame_of(v.addr);
      string t = tag_of(fr, v.wide);
      int    eb = (fr == 0) ? 0 : ((fr == 2 && v.wide) ? 2 : 1);
      logic [15:0] a = v.addr[15:0];
      logic [31:0] erd;
      logic [31:0] ew0;
      run_access(v.wr, v.wide, v.addr, v.wd);
      chk(n_beats == eb, t, "beat count", n_beats, eb);
      chk(n_cyc == eb + 1, t, "cycles to done", n_cyc, eb + 1);
      chk(got_err == (fr == 0), t, "error flag", {31'h0, got_err}, {31'h0, fr == 0});
      if (eb >= 1) begin
        ew0 = (fr == 1 && v.wide) ? v.wd : {16'h0, v.wd[15:0]};
        chk(b_addr[0] == a, "R2", "beat0 address", {16'h0, b_addr[0]}, {16'h0, a});
        chk(b_f1[0] == (fr == 1) && b_f2[0] == (fr == 2), "R2", "frame select",
            {30'h0, b_f1[0], b_f2[0]}, {30'h0, fr == 1, fr == 2});
        chk(b_wide[0] == (fr == 1 && v.wide), t, "width flag",
            {31'h0, b_wide[0]}, {31'h0, fr == 1 && v.wide});
        if (v.wr) chk(b_wdata[0] == ew0, t, "beat0 wdata", b_wdata[0], ew0);
      end
      if (eb == 2) begin
        chk(b_addr[1] == a + 16'd1, "R6", "beat1 address", {16'h0, b_addr[1]},
            {16'h0, a + 16'd1});
        chk(b_wide[1] == 1'b0, "R6", "beat1 width flag", {31'h0, b_wide[1]}, 32'h0);
        if (v.wr) chk(b_wdata[1] == {16'h0, v.wd[31:16]}, "R6", "beat1 wdata",
                      b_wdata[1], {16'h0, v.wd[31:16]});
      end
      if (!v.wr) begin
        if (fr == 0)               erd = 32'h0;
        else if (fr == 1)          erd = v.wide ? {w1(a + 16'd1), w1(a)} : {16'h0, w1(a)};
        else                       erd = v.wide ? {w2(a + 16'd1), w2(a)} : {16'h0, w2(a)};
        chk(got_rd == erd, t, "read data", got_rd, erd);
      end
      @(negedge clk);
      // R9: read data returns to zero once done has gone
      chk(rd_data == 32'h0 && !rd_done, "R9", "rd_data idle", rd_data, 32'h0);
    end

    // R7: read and write raised together; write must finish first
    begin
      int  order_ok = 1;
      int  got_w = 0;
      int  got_r = 0;
      logic [31:0] r_val = '0;
      @(negedge clk);
      wr_req = 1'b1; wr_addr = 32'h0000_0900; wr_wide = 1'b0; wr_data = 32'h0000_1111;
      rd_req = 1'b1; rd_addr = 32'h0000_7010; rd_wide = 1'b0;
      for (int k = 0; k < 12 && got_r == 0; k++) begin
        @(negedge clk);
        if (p_rd && got_w == 0) order_ok = 0;
        if (wr_done) begin got_w = 1; wr_req = 1'b0; end
        if (rd_done) begin
          got_r = 1; r_val = rd_data; rd_req = 1'b0;
          if (got_w == 0) order_ok = 0;
        end
      end
      chk(order_ok == 1 && got_w == 1 && got_r == 1, "R7", "write before read",
          {30'h0, got_w[0], got_r[0]}, 32'h3);
      chk(r_val == {16'h0, w2(16'h7010)}, "R7", "queued read data", r_val,
          {16'h0, w2(16'h7010)});
    end

    // R10: two back-to-back wide-frame reads never hold the select two cycles
    begin
      int run = 0;
      int max_run = 0;
      @(negedge clk);
      rd_req = 1'b1; rd_addr = 32'h0000_0C00; rd_wide = 1'b1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        run = f1_sel ? run + 1 : 0;
        if (run > max_run) max_run = run;
        if (rd_done) rd_addr = 32'h0000_0C02;
      end
      rd_req = 1'b0;
      chk(max_run == 1, "R10", "select length", max_run, 1);
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule